// File: doc/BRIEF.md
# Card Reader Wake-Up and Register Controller

This block is the control core of a magnetic-card reading peripheral that a host microcontroller manages over a mode-0 SPI link. The host configures which tracks and token features are active through a configuration word. It arms the reader by command and then follows a four-state sequence (off, armed, swipe in progress, data ready for extraction), which it can read back through a status word. A card front end, outside this block, reports three events as single-cycle strobes: a swipe has begun, decoded data is available, and the track read-out has finished.

While the host keeps the slave deselected, the block reuses its serial output as an active-low wake line that carries two requests, each with its own clearing rule. The card-present request is raised when a swipe starts and is dropped only by an acknowledge write. The data-ready request is raised when data becomes available and is dropped only by a read-track or reset command. Once the host selects the slave, the line goes back to carrying ordinary serial read data. The block also drives the enable outputs for tracks, token modes and data scrambling to the rest of the reader.

Top module: `card_wake_ctrl`

## Requirements
- R1: After reset the state is OFF (status code 0), the configuration word is 0x0000, and MISO is high while SSELn is high.
- R2: The configuration word at address 0x00 stores only bits 15, 14, 13, 11, 10 and 8 (mask 0xED00). Written values in the other bits are dropped, and those bits read back as zero.
- R3: tokenEn = NOT bit 15, tokenExtEn = NOT bit 15 AND NOT bit 14, trackAEn = NOT bit 13, trackCEn = NOT bit 11. trackBEn is always 1.
- R4: A frame is 24 SCLK cycles in mode 0, sent MSB first: a header byte whose bit 7 is 1 for a read and whose bits 6:0 are the address, then 16 data bits. A read of address 0x02 returns the state code in bits 1:0 (OFF=0, ATR=1, SWIPE=2, EXTRACT=3) with zeros above. Unlisted addresses read as zero.
- R5: Writing 0x0002 to the command register at 0x01 moves OFF to ATR. swipeStart moves ATR to SWIPE, dataAvail moves SWIPE to EXTRACT, and trackReadDone moves EXTRACT to ATR. Any strobe or arm command given in another state is ignored.
- R6: Entering SWIPE raises the card-present request. It is cleared only by a write to 0x05 with data bit 0 = 1. A write with bit 0 = 0 leaves it set.
- R7: While configuration bit 10 is 1, a pending card-present request does not pull MISO low.
- R8: Entering EXTRACT raises the data-ready request, which always pulls MISO low while deselected. It is cleared by the read-track command (0x0003 to 0x01) or the reset command. An acknowledge write does not clear it.
- R9: While SSELn is low, MISO carries read data only. A request raised during a frame shows on MISO as soon as SSELn rises.
- R10: The reset command (0x0001 to 0x01) returns the state to OFF from any state and clears both requests.
- R11: obfuscateEn is 1 only in EXTRACT with configuration bit 8 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the SPI pins are oversampled by it |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock |
| sselN | input | 1 | SPI slave select, active low |
| mosi | input | 1 | SPI data from host |
| miso | output | 1 | SPI data to host; active-low wake line while deselected |
| swipeStart | input | 1 | Front-end strobe: a swipe has begun |
| dataAvail | input | 1 | Front-end strobe: decoded card data is available |
| trackReadDone | input | 1 | Front-end strobe: track read-out finished |
| tokenEn | output | 1 | Token capture enabled |
| tokenExtEn | output | 1 | Extended token mode enabled |
| trackAEn | output | 1 | Track A enabled |
| trackBEn | output | 1 | Track B enabled (always 1) |
| trackCEn | output | 1 | Track C enabled |
| obfuscateEn | output | 1 | Output data scrambling active |

## Verification
Directed sequences walk the full swipe cycle twice: once with the card-present request enabled and once with it masked. Together they separate the request that the acknowledge clears from the one that only a command clears. One directed frame raises data-available in the middle of an acknowledge write, which shows whether the line is held off during the frame and asserted right at deselect. Random configuration words, some with reserved bits set, test the write mask and the enable decode. A random mix of strobes and commands is then compared against a bench state model after every step, by status read and by idle line level, so that out-of-state strobes are also tried.

// File: rtl/card_wake_pkg.sv
package card_wake_pkg;

  typedef enum logic [1:0] {
    ST_OFF     = 2'd0,
    ST_ATR     = 2'd1,
    ST_SWIPE   = 2'd2,
    ST_EXTRACT = 2'd3
  } wakeStateT;

  // strobes from the serial datapath to the control
  typedef struct packed {
    logic cfgWr;
    logic ackWr;
    logic cmdReset;
    logic cmdArm;
    logic cmdRead;
  } hostOpT;

  localparam int ADDR_CFG  = 0;
  localparam int ADDR_CMD  = 1;
  localparam int ADDR_STAT = 2;
  localparam int ADDR_ACK  = 5;

  localparam int CMD_RESET = 1;
  localparam int CMD_ARM   = 2;
  localparam int CMD_READ  = 3;

  localparam logic [15:0] CFG_MASK = 16'hED00;
  localparam int BIT_TOKEN_DIS = 15;
  localparam int BIT_TOKX_DIS  = 14;
  localparam int BIT_TRKA_DIS  = 13;
  localparam int BIT_TRKC_DIS  = 11;
  localparam int BIT_IRQ_DIS   = 10;
  localparam int BIT_OBF_DIS   = 8;

endpackage

// File: rtl/card_wake_spi_dp.sv
module card_wake_spi_dp
  import card_wake_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              sselN,
  input  logic              mosi,
  input  wakeStateT         state,
  output logic [DATA_W-1:0] cfgReg,
  output hostOpT            hostOp,
  output logic              spiOut
);
  localparam int HDR_W   = ADDR_W + 1;
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic                 sclkQ;
  logic [FRAME_W-2:0]   rxShift;
  logic [CNT_W-1:0]     bitCnt;
  logic [DATA_W-1:0]    txShift;
  logic [DATA_W-1:0]    rdData;
  logic [FRAME_W-1:0]   rxWord;
  logic                 sclkRise, sclkFall, hdrDone, frameDone, wrFrame;
  logic [ADDR_W-1:0]    hdrAddr, frmAddr;
  logic [DATA_W-1:0]    frmData;

  always_comb begin
    rxWord    = {rxShift, mosi};
    sclkRise  = !sselN && sclk && !sclkQ;
    sclkFall  = !sselN && !sclk && sclkQ;
    hdrDone   = sclkRise && (bitCnt == CNT_W'(HDR_W - 1));
    frameDone = sclkRise && (bitCnt == CNT_W'(FRAME_W - 1));
    hdrAddr   = rxWord[ADDR_W-1:0];
    frmAddr   = rxWord[DATA_W +: ADDR_W];
    frmData   = rxWord[DATA_W-1:0];
    wrFrame   = frameDone && !rxWord[FRAME_W-1];
  end

  // read data selected once the header byte is complete
  always_comb begin
    rdData = '0;
    if (hdrAddr == ADDR_W'(ADDR_CFG))       rdData = cfgReg;
    else if (hdrAddr == ADDR_W'(ADDR_STAT)) rdData = DATA_W'(state);
  end

  always_comb begin
    hostOp.cfgWr    = wrFrame && (frmAddr == ADDR_W'(ADDR_CFG));
    hostOp.ackWr    = wrFrame && (frmAddr == ADDR_W'(ADDR_ACK)) && frmData[0];
    hostOp.cmdReset = wrFrame && (frmAddr == ADDR_W'(ADDR_CMD)) && (frmData == DATA_W'(CMD_RESET));
    hostOp.cmdArm   = wrFrame && (frmAddr == ADDR_W'(ADDR_CMD)) && (frmData == DATA_W'(CMD_ARM));
    hostOp.cmdRead  = wrFrame && (frmAddr == ADDR_W'(ADDR_CMD)) && (frmData == DATA_W'(CMD_READ));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ   <= 1'b0;
      rxShift <= '0;
      bitCnt  <= '0;
      txShift <= '0;
    end else begin
      sclkQ <= sclk;
      if (sselN) begin
        bitCnt  <= '0;
        txShift <= '0;
      end else begin
        if (sclkRise && (bitCnt != CNT_W'(FRAME_W))) begin
          rxShift <= rxWord[FRAME_W-2:0];
          bitCnt  <= bitCnt + 1'b1;
        end
        if (hdrDone)
          txShift <= rxWord[HDR_W-1] ? rdData : '0;
        else if (sclkFall && (bitCnt > CNT_W'(HDR_W)))
          txShift <= {txShift[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cfgReg <= '0;
    else if (hostOp.cfgWr) cfgReg <= frmData & DATA_W'(CFG_MASK);
  end

  assign spiOut = txShift[DATA_W-1];

endmodule

// File: rtl/card_wake_fsm.sv
module card_wake_fsm
  import card_wake_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  hostOpT    hostOp,
  input  logic      swipeStart,
  input  logic      dataAvail,
  input  logic      trackReadDone,
  output wakeStateT state,
  output logic      cpFlag,
  output logic      drFlag
);
  wakeStateT nextState;
  logic      enterSwipe, enterExtract;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_OFF:     if (hostOp.cmdArm) nextState = ST_ATR;
      ST_ATR:     if (swipeStart)    nextState = ST_SWIPE;
      ST_SWIPE:   if (dataAvail)     nextState = ST_EXTRACT;
      ST_EXTRACT: if (trackReadDone) nextState = ST_ATR;
      default:                       nextState = ST_OFF;
    endcase
    if (hostOp.cmdReset) nextState = ST_OFF;
    enterSwipe   = (nextState == ST_SWIPE) && (state != ST_SWIPE);
    enterExtract = (nextState == ST_EXTRACT) && (state != ST_EXTRACT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_OFF;
      cpFlag <= 1'b0;
      drFlag <= 1'b0;
    end else begin
      state <= nextState;
      if (hostOp.cmdReset)   cpFlag <= 1'b0;
      else if (enterSwipe)   cpFlag <= 1'b1;
      else if (hostOp.ackWr) cpFlag <= 1'b0;
      if (hostOp.cmdReset)     drFlag <= 1'b0;
      else if (enterExtract)   drFlag <= 1'b1;
      else if (hostOp.cmdRead) drFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/card_wake_ctrl.sv
module card_wake_ctrl
  import card_wake_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclk,
  input  logic sselN,
  input  logic mosi,
  output logic miso,
  input  logic swipeStart,
  input  logic dataAvail,
  input  logic trackReadDone,
  output logic tokenEn,
  output logic tokenExtEn,
  output logic trackAEn,
  output logic trackBEn,
  output logic trackCEn,
  output logic obfuscateEn
);
  logic [DATA_W-1:0] cfgReg;
  hostOpT            hostOp;
  wakeStateT         ctrlState;
  logic              cpFlag, drFlag, spiOut, irqPend;

  card_wake_spi_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .sclk(sclk), .sselN(sselN), .mosi(mosi),
    .state(ctrlState), .cfgReg(cfgReg), .hostOp(hostOp), .spiOut(spiOut)
  );

  card_wake_fsm u_fsm (
    .clk(clk), .rstN(rstN), .hostOp(hostOp), .swipeStart(swipeStart),
    .dataAvail(dataAvail), .trackReadDone(trackReadDone),
    .state(ctrlState), .cpFlag(cpFlag), .drFlag(drFlag)
  );

  assign irqPend     = (cpFlag && !cfgReg[BIT_IRQ_DIS]) || drFlag;
  assign miso        = sselN ? !irqPend : spiOut;
  assign tokenEn     = !cfgReg[BIT_TOKEN_DIS];
  assign tokenExtEn  = !cfgReg[BIT_TOKEN_DIS] && !cfgReg[BIT_TOKX_DIS];
  assign trackAEn    = !cfgReg[BIT_TRKA_DIS];
  assign trackBEn    = 1'b1;
  assign trackCEn    = !cfgReg[BIT_TRKC_DIS];
  assign obfuscateEn = (ctrlState == ST_EXTRACT) && !cfgReg[BIT_OBF_DIS];

endmodule

// File: rtl/card_wake_chk.sv
module card_wake_chk
  import card_wake_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      sselN,
  input logic      miso,
  input logic      swipeStart,
  input logic      obfuscateEn,
  input logic      cfgObfDis,
  input hostOpT    hostOp,
  input wakeStateT state,
  input logic      cpFlag,
  input logic      drFlag
);
  AST_SWIPE_FROM_ATR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_SWIPE) |-> ($past(state) == ST_ATR) && $past(swipeStart)); // R5
  AST_EXTRACT_RAISES_DR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_EXTRACT) |-> drFlag); // R8
  AST_RESET_CMD_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    hostOp.cmdReset |=> (state == ST_OFF) && !cpFlag && !drFlag); // R10
  AST_CP_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    cpFlag && !hostOp.ackWr && !hostOp.cmdReset |=> cpFlag); // R6
  AST_DR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    drFlag && !hostOp.cmdRead && !hostOp.cmdReset |=> drFlag); // R8
  AST_OBF_GATED: assert property (@(posedge clk) disable iff (!rstN)
    obfuscateEn |-> (state == ST_EXTRACT) && !cfgObfDis); // R11
  AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    sselN && drFlag |-> !miso); // R9
endmodule

bind card_wake_ctrl card_wake_chk u_chk (
  .clk(clk), .rstN(rstN), .sselN(sselN), .miso(miso), .swipeStart(swipeStart),
  .obfuscateEn(obfuscateEn), .cfgObfDis(cfgReg[8]), .hostOp(hostOp),
  .state(ctrlState), .cpFlag(cpFlag), .drFlag(drFlag)
);

// File: tb/test_card_wake_ctrl.sv
module test_card_wake_ctrl;
  logic clk = 1'b0, rstN = 1'b0;
  logic sclk = 1'b0, sselN = 1'b1, mosi = 1'b0;
  logic swipeStart = 1'b0, dataAvail = 1'b0, trackReadDone = 1'b0;
  logic miso, tokenEn, tokenExtEn, trackAEn, trackBEn, trackCEn, obfuscateEn;
  int   nChecks = 0, nFails = 0;

  always #2 clk = ~clk;

  card_wake_ctrl i_card_wake_ctrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .sselN(sselN), .mosi(mosi), .miso(miso),
    .swipeStart(swipeStart), .dataAvail(dataAvail), .trackReadDone(trackReadDone),
    .tokenEn(tokenEn), .tokenExtEn(tokenExtEn), .trackAEn(trackAEn),
    .trackBEn(trackBEn), .trackCEn(trackCEn), .obfuscateEn(obfuscateEn)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%04h expected 0x%04h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] expEn(input logic [15:0] c);
    return {~c[15], ~c[15] & ~c[14], ~c[13], 1'b1, ~c[11]};
  endfunction

  function automatic logic expMiso(input logic [15:0] c, input logic cp, input logic dr);
    return !((cp && !c[10]) || dr);
  endfunction

  task automatic spiFrame(input logic rd, input logic [6:0] addr, input logic [15:0] wdata,
                          input int pulseBit, output logic [15:0] rdata);
    logic [23:0] word;
    word  = {rd, addr, wdata};
    rdata = '0;
    @(negedge clk) sselN = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 24; i++) begin
      mosi = word[23-i];
      repeat (2) @(negedge clk);
      if (i >= 8) rdata[23-i] = miso;
      sclk = 1'b1;
      if (i == pulseBit) dataAvail = 1'b1;
      @(negedge clk) dataAvail = 1'b0;
      @(negedge clk) sclk = 1'b0;
    end
    repeat (2) @(negedge clk);
    sselN = 1'b1;
  endtask

  task automatic wr(input logic [6:0] addr, input logic [15:0] d);
    logic [15:0] unused;
    spiFrame(1'b0, addr, d, -1, unused);
    @(negedge clk);
  endtask

  task automatic rd(input logic [6:0] addr, output logic [15:0] d);
    spiFrame(1'b1, addr, 16'h0, -1, d);
    @(negedge clk);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: swipeStart = 1'b1;
      1: dataAvail = 1'b1;
      default: trackReadDone = 1'b1;
    endcase
    @(negedge clk);
    swipeStart = 1'b0; dataAvail = 1'b0; trackReadDone = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    nFails++; nChecks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [15:0] d, cfg;
    logic [1:0]  mSt;
    logic        mCp, mDr;
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "idle miso", {15'b0, miso}, 16'h1);
    rd(7'h02, d); chk("R1", "state", d, 16'h0);
    rd(7'h00, d); chk("R1", "cfg", d, 16'h0);
    chk("R3", "enables at reset", {11'b0, tokenEn, tokenExtEn, trackAEn, trackBEn, trackCEn}, 16'h1F);
    // R2 reserved bits dropped
    wr(7'h00, 16'hFFFF); rd(7'h00, d); chk("R2", "cfg all ones", d, 16'hED00);
    chk("R3", "enables all disabled", {11'b0, tokenEn, tokenExtEn, trackAEn, trackBEn, trackCEn}, 16'h02);
    // R4 unlisted address reads zero
    rd(7'h33, d); chk("R4", "unlisted read", d, 16'h0);
    wr(7'h00, 16'h0000);
    // R5 strobes ignored in OFF
    pulse(0); pulse(1);
    rd(7'h02, d); chk("R5", "strobes in OFF", d, 16'h0);
    chk("R5", "miso after ignored strobes", {15'b0, miso}, 16'h1);
    wr(7'h01, 16'h0002); rd(7'h02, d); chk("R5", "arm to ATR", d, 16'h1);
    pulse(0);
    chk("R6", "card present wake", {15'b0, miso}, 16'h0);
    rd(7'h02, d); chk("R5", "SWIPE state", d, 16'h2);
    wr(7'h05, 16'h0000); chk("R6", "ack bit0=0 keeps", {15'b0, miso}, 16'h0);
    wr(7'h05, 16'h0001); chk("R6", "ack clears", {15'b0, miso}, 16'h1);
    pulse(1);
    chk("R8", "data ready wake", {15'b0, miso}, 16'h0);
    rd(7'h02, d); chk("R4", "EXTRACT state read", d, 16'h3);
    chk("R11", "obfuscate in EXTRACT", {15'b0, obfuscateEn}, 16'h1);
    wr(7'h05, 16'h0001); chk("R8", "ack ignored for data ready", {15'b0, miso}, 16'h0);
    wr(7'h01, 16'h0003); chk("R8", "read cmd clears", {15'b0, miso}, 16'h1);
    pulse(2); rd(7'h02, d); chk("R5", "done to ATR", d, 16'h1);
    chk("R11", "no obfuscate outside EXTRACT", {15'b0, obfuscateEn}, 16'h0);
    // R7 card present masked, R11 obf disabled
    wr(7'h00, 16'h0500);
    pulse(0); chk("R7", "masked card present", {15'b0, miso}, 16'h1);
    // R9 data ready raised mid ack frame
    spiFrame(1'b0, 7'h05, 16'h0001, 12, d);
    chk("R9", "miso at deselect", {15'b0, miso}, 16'h0);
    @(negedge clk);
    rd(7'h02, d); chk("R5", "EXTRACT after mid-frame", d, 16'h3);
    chk("R11", "obf disabled by bit 8", {15'b0, obfuscateEn}, 16'h0);
    // R9 selected: miso carries data, not the low wake level
    rd(7'h00, d); chk("R9", "read cfg while pending", d, 16'h0500);
    // R10 reset command
    wr(7'h01, 16'h0001);
    chk("R10", "miso after reset cmd", {15'b0, miso}, 16'h1);
    rd(7'h02, d); chk("R10", "state after reset cmd", d, 16'h0);
    // random configuration words
    for (int k = 0; k < 12; k++) begin
      cfg = 16'($urandom);
      wr(7'h00, cfg); rd(7'h00, d);
      chk("R2", "random cfg readback", d, cfg & 16'hED00);
      chk("R3", "random enables", {11'b0, tokenEn, tokenExtEn, trackAEn, trackBEn, trackCEn},
          {11'b0, expEn(cfg & 16'hED00)});
    end
    // random strobe/command mix against a model
    cfg = 16'h0000; wr(7'h00, cfg);
    mSt = 2'd0; mCp = 1'b0; mDr = 1'b0;
    for (int k = 0; k < 60; k++) begin
      int op;
      op = int'($urandom_range(0, 6));
      case (op)
        0: begin pulse(0); if (mSt == 2'd1) begin mSt = 2'd2; mCp = 1'b1; end end
        1: begin pulse(1); if (mSt == 2'd2) begin mSt = 2'd3; mDr = 1'b1; end end
        2: begin pulse(2); if (mSt == 2'd3) mSt = 2'd1; end
        3: begin wr(7'h01, 16'h0002); if (mSt == 2'd0) mSt = 2'd1; end
        4: begin wr(7'h01, 16'h0001); mSt = 2'd0; mCp = 1'b0; mDr = 1'b0; end
        5: begin wr(7'h01, 16'h0003); mDr = 1'b0; end
        default: begin wr(7'h05, 16'h0001); mCp = 1'b0; end
      endcase
      chk("R6", "model miso", {15'b0, miso}, {15'b0, expMiso(cfg, mCp, mDr)});
      rd(7'h02, d); chk("R5", "model state", d, {14'b0, mSt});
    end
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule